// File: doc/BRIEF.md
# Compressed Super-Block Tag Lookup

This block is the tag lookup stage of a set-associative last-level cache that stores compressed data. Each tag entry is paired with exactly one 64-byte data entry and describes which blocks of a four-block super-block are packed into that data entry. The packing, and therefore the entry layout, depends on the compression factor: four blocks of 16 bytes each, two blocks of 32 bytes each, or one uncompressed 64-byte block.

A request carries a physical address. The block selects one set from the super-block index, compares the super-block tag in every way of that set, and decodes each way's metadata for the requested block id. One cycle later it reports hit or miss, the hitting way, which 16-byte sub-blocks of that way's data entry hold the block, the block's 3-bit coherence state, a per-way super-block match vector and an error flag for duplicate valid copies. A write port loads tag entries, standing in for the fill path.

Top module: `ctbl_lookup`

## Requirements
- R1: The request address is split, from the least significant end, into a 6-bit byte offset, a 2-bit block id, a super-block index of log2(NUM_SETS) bits and a super-block tag of SB_TAG_W bits. Only the index selects the set, and any way of that set can hold any block.
- R2: After reset rspValid, rspHit, rspWay, rspMask, rspState, rspTagMatch and rspMultiHit are all zero. A request in the cycle of clock edge n produces rspValid high after edge n, together with all its results. Without a request rspValid is low and the other outputs keep their last values.
- R3: Metadata bit 12 set means factor four: bits [3i+2:3i] hold the coherence state of block id i, for i from 0 to 3, and block i occupies quarter i.
- R4: Bit 12 clear and bit 11 set means factor two: bits [9:8] and [7:5] are the block id and state held in the upper half, and bits [4:3] and [2:0] those held in the lower half. Any two ids may be paired, and the upper half is tested first.
- R5: Bits 12 and 11 both clear means uncompressed: bits [4:3] are the block id and bits [2:0] its state.
- R6: State 3'b000 is invalid. A hit needs a super-block tag match and a non-zero state for the requested id. On a miss rspWay, rspMask and rspState are zero.
- R7: On a hit rspMask bit k is set for each 16-byte sub-block k (0 is lowest) holding the block: 1<<id for factor four, 4'b1100 for the upper half, 4'b0011 for the lower half and 4'b1111 when uncompressed.
- R8: rspTagMatch bit w is set when way w of the indexed set carries the requested super-block tag, whatever its states.
- R9: When more than one way holds the requested block valid, rspMultiHit is set and the lowest such way is reported.
- R10: A write of set, way, tag and metadata takes effect for requests from the next cycle. A request in the same cycle as the write sees the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, clears the tag store and outputs |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | ADDR_W | Physical address of the requested byte |
| wrEn | input | 1 | Tag entry write strobe |
| wrSet | input | SET_W | Set to write |
| wrWay | input | WAY_W | Way to write |
| wrTag | input | SB_TAG_W | Super-block tag to store |
| wrMeta | input | 13 | Format bits, block ids and states to store |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Requested block found valid |
| rspWay | output | WAY_W | Hitting way |
| rspMask | output | 4 | Sub-blocks holding the block |
| rspState | output | 3 | Coherence state of the block |
| rspTagMatch | output | NUM_WAYS | Ways whose super-block tag matched |
| rspMultiHit | output | 1 | More than one way holds the block valid |

## Verification
Every lookup result is due on the clock edge that follows the request, so the bench drives inputs on falling edges and compares all outputs on the next falling edge. The reference model predicts the result from its own copy of the tag store as it stood before any write in the same cycle. It then applies the write, which gives the same-cycle ordering of R10. On cycles without a request, the outputs are compared against the values held from the last response.

// File: rtl/ctbl_pkg.sv
package ctbl_pkg;
  localparam int META_W = 13;
  localparam int CS_W   = 3;
  localparam int BID_W  = 2;
  localparam int SUB_N  = 4;
  localparam int OFS_W  = 6;

  typedef struct packed {
    logic writeTag;
    logic loadRsp;
  } ctlStrobes_t;

  typedef struct packed {
    logic            valid;
    logic [SUB_N-1:0] mask;
    logic [CS_W-1:0]  state;
  } wayDec_t;
endpackage

// File: rtl/ctbl_way_decode.sv
module ctbl_way_decode
  import ctbl_pkg::*;
(
  input  logic [META_W-1:0] meta,
  input  logic [BID_W-1:0]  blkId,
  output wayDec_t           dec
);
  logic [BID_W-1:0] upId, loId;
  logic [CS_W-1:0]  upCs, loCs;

  assign upId = meta[9:8];
  assign upCs = meta[7:5];
  assign loId = meta[4:3];
  assign loCs = meta[2:0];

  always_comb begin
    dec = '0;
    if (meta[12]) begin
      dec.state = meta[CS_W*blkId +: CS_W];
      dec.mask  = SUB_N'(1) << blkId;
    end else if (meta[11]) begin
      if (upId == blkId && upCs != '0) begin
        dec.state = upCs;
        dec.mask  = 4'b1100;
      end else if (loId == blkId) begin
        dec.state = loCs;
        dec.mask  = 4'b0011;
      end
    end else if (loId == blkId) begin
      dec.state = loCs;
      dec.mask  = 4'b1111;
    end
    dec.valid = (dec.state != '0);
    if (!dec.valid) dec.mask = '0;
  end
endmodule

// File: rtl/ctbl_lookup_ctrl.sv
module ctbl_lookup_ctrl
  import ctbl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        wrEn,
  output ctlStrobes_t strobes,
  output logic        rspValid
);
  always_comb begin
    strobes.writeTag = wrEn;
    strobes.loadRsp  = reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end
endmodule

// File: rtl/ctbl_lookup_dp.sv
module ctbl_lookup_dp
  import ctbl_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int NUM_SETS = 16,
  parameter int SB_TAG_W = 12,
  parameter int SET_W    = $clog2(NUM_SETS),
  parameter int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [SB_TAG_W-1:0] reqTag,
  input  logic [SET_W-1:0]    reqSet,
  input  logic [BID_W-1:0]    reqBlk,
  input  logic [SET_W-1:0]    wrSet,
  input  logic [WAY_W-1:0]    wrWay,
  input  logic [SB_TAG_W-1:0] wrTag,
  input  logic [META_W-1:0]   wrMeta,
  output logic                rspHit,
  output logic [WAY_W-1:0]    rspWay,
  output logic [SUB_N-1:0]    rspMask,
  output logic [CS_W-1:0]     rspState,
  output logic [NUM_WAYS-1:0] rspTagMatch,
  output logic                rspMultiHit
);
  logic [SB_TAG_W-1:0] tagMem  [NUM_SETS][NUM_WAYS];
  logic [META_W-1:0]   metaMem [NUM_SETS][NUM_WAYS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          tagMem[s][w]  <= '0;
          metaMem[s][w] <= '0;
        end
      end
    end else if (strobes.writeTag) begin
      tagMem[wrSet][wrWay]  <= wrTag;
      metaMem[wrSet][wrWay] <= wrMeta;
    end
  end

  logic [NUM_WAYS-1:0] tagMatch;
  logic [NUM_WAYS-1:0] wayValid;
  wayDec_t             wayDec [NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign tagMatch[w] = (tagMem[reqSet][w] == reqTag);
    ctbl_way_decode u_dec (
      .meta  (metaMem[reqSet][w]),
      .blkId (reqBlk),
      .dec   (wayDec[w])
    );
    assign wayValid[w] = tagMatch[w] & wayDec[w].valid;
  end

  logic             selHit, selMulti;
  logic [WAY_W-1:0] selWay;
  logic [SUB_N-1:0] selMask;
  logic [CS_W-1:0]  selState;

  always_comb begin
    selHit   = 1'b0;
    selMulti = 1'b0;
    selWay   = '0;
    selMask  = '0;
    selState = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (wayValid[w]) begin
        if (selHit) begin
          selMulti = 1'b1;
        end else begin
          selHit   = 1'b1;
          selWay   = WAY_W'(w);
          selMask  = wayDec[w].mask;
          selState = wayDec[w].state;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspHit      <= 1'b0;
      rspWay      <= '0;
      rspMask     <= '0;
      rspState    <= '0;
      rspTagMatch <= '0;
      rspMultiHit <= 1'b0;
    end else if (strobes.loadRsp) begin
      rspHit      <= selHit;
      rspWay      <= selWay;
      rspMask     <= selMask;
      rspState    <= selState;
      rspTagMatch <= tagMatch;
      rspMultiHit <= selMulti;
    end
  end
endmodule

// File: rtl/ctbl_lookup.sv
module ctbl_lookup
  import ctbl_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int NUM_SETS = 16,
  parameter int SB_TAG_W = 12,
  parameter int SET_W    = $clog2(NUM_SETS),
  parameter int WAY_W    = $clog2(NUM_WAYS),
  parameter int ADDR_W   = SB_TAG_W + SET_W + 2 + 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                wrEn,
  input  logic [SET_W-1:0]    wrSet,
  input  logic [WAY_W-1:0]    wrWay,
  input  logic [SB_TAG_W-1:0] wrTag,
  input  logic [12:0]         wrMeta,
  output logic                rspValid,
  output logic                rspHit,
  output logic [WAY_W-1:0]    rspWay,
  output logic [3:0]          rspMask,
  output logic [2:0]          rspState,
  output logic [NUM_WAYS-1:0] rspTagMatch,
  output logic                rspMultiHit
);
  localparam int BLK_LSB = OFS_W;
  localparam int SET_LSB = OFS_W + BID_W;
  localparam int TAG_LSB = SET_LSB + SET_W;

  ctlStrobes_t strobes;

  ctbl_lookup_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .wrEn     (wrEn),
    .strobes  (strobes),
    .rspValid (rspValid)
  );

  ctbl_lookup_dp #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_SETS (NUM_SETS),
    .SB_TAG_W (SB_TAG_W),
    .SET_W    (SET_W),
    .WAY_W    (WAY_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqTag      (reqAddr[TAG_LSB +: SB_TAG_W]),
    .reqSet      (reqAddr[SET_LSB +: SET_W]),
    .reqBlk      (reqAddr[BLK_LSB +: BID_W]),
    .wrSet       (wrSet),
    .wrWay       (wrWay),
    .wrTag       (wrTag),
    .wrMeta      (wrMeta),
    .rspHit      (rspHit),
    .rspWay      (rspWay),
    .rspMask     (rspMask),
    .rspState    (rspState),
    .rspTagMatch (rspTagMatch),
    .rspMultiHit (rspMultiHit)
  );
endmodule

// File: rtl/ctbl_lookup_chk.sv
module ctbl_lookup_chk #(
  parameter int NUM_WAYS = 8,
  parameter int WAY_W    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                rspValid,
  input logic                rspHit,
  input logic [WAY_W-1:0]    rspWay,
  input logic [3:0]          rspMask,
  input logic [2:0]          rspState,
  input logic [NUM_WAYS-1:0] rspTagMatch,
  input logic                rspMultiHit
);
  // R2: a response follows each request by one edge
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  // R2: held results stay put between requests
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(rspHit) && $stable(rspMask) && $stable(rspTagMatch));
  // R7: hit mask is one quarter, one half or whole entry
  p_mask_shape_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> ($countones(rspMask) == 1 || rspMask == 4'b0011 ||
                rspMask == 4'b1100 || rspMask == 4'b1111));
  // R6: a hit carries a valid state, a miss carries nothing
  p_hit_state_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspState != 3'b000);
  p_miss_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> (rspMask == 4'b0 && rspState == 3'b0 && rspWay == '0));
  // R8: the hitting way must be among the tag matches
  p_hit_tag_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspTagMatch[rspWay]);
  // R9: duplicate flag only with a hit and at least two matches
  p_multi_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspMultiHit |-> (rspHit && $countones(rspTagMatch) >= 2));
endmodule

bind ctbl_lookup ctbl_lookup_chk #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .rspValid    (rspValid),
  .rspHit      (rspHit),
  .rspWay      (rspWay),
  .rspMask     (rspMask),
  .rspState    (rspState),
  .rspTagMatch (rspTagMatch),
  .rspMultiHit (rspMultiHit)
);

// File: tb/ctbl_lookup_tb.sv
module ctbl_lookup_tb;
  localparam int NW = 8;
  localparam int NS = 16;
  localparam int TW = 12;
  localparam int SW = 4;
  localparam int WW = 3;
  localparam int AW = TW + SW + 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          wrEn = 1'b0;
  logic [SW-1:0] wrSet = '0;
  logic [WW-1:0] wrWay = '0;
  logic [TW-1:0] wrTag = '0;
  logic [12:0]   wrMeta = '0;
  logic          rspValid, rspHit, rspMultiHit;
  logic [WW-1:0] rspWay;
  logic [3:0]    rspMask;
  logic [2:0]    rspState;
  logic [NW-1:0] rspTagMatch;

  always #10 clk = ~clk;

  ctbl_lookup u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .wrEn(wrEn), .wrSet(wrSet), .wrWay(wrWay), .wrTag(wrTag), .wrMeta(wrMeta),
    .rspValid(rspValid), .rspHit(rspHit), .rspWay(rspWay), .rspMask(rspMask),
    .rspState(rspState), .rspTagMatch(rspTagMatch), .rspMultiHit(rspMultiHit)
  );

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  int mTag  [NS][NW];
  int mMeta [NS][NW];

  int eValid = 0, eHit = 0, eWay = 0, eMask = 0, eState = 0, eTm = 0, eMulti = 0;

  task automatic cmp(string req, string name, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, name, act, exp, cycles);
    end
  endtask

  function automatic int mk4(int s3, int s2, int s1, int s0);
    return 4096 | (s3 << 9) | (s2 << 6) | (s1 << 3) | s0;
  endfunction
  function automatic int mk2(int idU, int csU, int idL, int csL);
    return 2048 | (idU << 8) | (csU << 5) | (idL << 3) | csL;
  endfunction
  function automatic int mk1(int id, int cs);
    return (id << 3) | cs;
  endfunction

  // R1: address layout {tag, set, block id, byte offset}
  function automatic logic [AW-1:0] addr(int tag, int set, int bid, int ofs);
    return {TW'(tag), SW'(set), 2'(bid), 6'(ofs)};
  endfunction

  task automatic predict(int set, int tag, int bid);
    int st, mk, m;
    eHit = 0; eMulti = 0; eWay = 0; eMask = 0; eState = 0; eTm = 0;
    for (int w = 0; w < NW; w++) begin
      if (mTag[set][w] == tag) begin
        eTm |= (1 << w);
        m = mMeta[set][w];
        st = 0; mk = 0;
        if ((m >> 12) & 1) begin
          st = (m >> (3 * bid)) & 7; mk = 1 << bid;
        end else if ((m >> 11) & 1) begin
          if (((m >> 8) & 3) == bid && ((m >> 5) & 7) != 0) begin
            st = (m >> 5) & 7; mk = 12;
          end else if (((m >> 3) & 3) == bid) begin
            st = m & 7; mk = 3;
          end
        end else if (((m >> 3) & 3) == bid) begin
          st = m & 7; mk = 15;
        end
        if (st != 0) begin
          if (eHit != 0) eMulti = 1;
          else begin eHit = 1; eWay = w; eMask = mk; eState = st; end
        end
      end
    end
  endtask

  task automatic checkAll();
    cmp("R2", "rspValid", int'(rspValid), eValid);
    cmp("R6", "rspHit", int'(rspHit), eHit);
    cmp("R9", "rspWay", int'(rspWay), eWay);
    cmp("R7", "rspMask", int'(rspMask), eMask);
    cmp("R3/R4/R5", "rspState", int'(rspState), eState);
    cmp("R8", "rspTagMatch", int'(rspTagMatch), eTm);
    cmp("R9", "rspMultiHit", int'(rspMultiHit), eMulti);
  endtask

  // one cycle: check outputs from the previous edge, then drive new inputs
  task automatic step(bit rq, int tag, int set, int bid, bit we,
                      int ws, int ww, int wt, int wm);
    checkAll();
    eValid = rq ? 1 : 0;
    if (rq) predict(set, tag, bid);
    if (we) begin // R10: write lands after the lookup of this cycle
      mTag[ws][ww]  = wt;
      mMeta[ws][ww] = wm;
    end
    reqValid = rq;
    reqAddr  = addr(tag, set, bid, $urandom_range(0, 63));
    wrEn     = we;
    wrSet    = SW'(ws);
    wrWay    = WW'(ww);
    wrTag    = TW'(wt);
    wrMeta   = 13'(wm);
    @(negedge clk);
    cycles++;
  endtask

  task automatic wr(int s, int w, int t, int m);
    step(0, 0, 0, 0, 1, s, w, t, m);
  endtask
  task automatic rd(int t, int s, int b);
    step(1, t, s, b, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin mTag[s][w] = 0; mMeta[s][w] = 0; end
    repeat (3) @(negedge clk);
    checkAll(); // R2: reset state
    rstN = 1'b1;
    @(negedge clk);

    // R3: factor four, block 2 in quarter 2
    wr(3, 7, 'h0AB, mk4(1, 5, 2, 3));
    rd('h0AB, 3, 2);
    rd('h0AB, 3, 0);
    rd('h0AB, 4, 2);           // R1: other set misses
    // R4: non-adjacent ids 3 (upper) and 1 (lower)
    wr(7, 4, 'h123, mk2(3, 4, 1, 2));
    rd('h123, 7, 3);
    rd('h123, 7, 1);
    rd('h123, 7, 2);           // R6: tag match, id absent
    // R5: uncompressed block in way 0
    wr(7, 0, 'h123, mk1(2, 6));
    rd('h123, 7, 2);
    // R6: matching tag with invalid state
    wr(9, 2, 'h055, mk1(1, 0));
    rd('h055, 9, 1);
    // R9: two valid copies of one block
    wr(9, 5, 'h055, mk4(0, 0, 7, 0));
    wr(9, 6, 'h055, mk1(1, 3));
    rd('h055, 9, 1);
    // R10: write and lookup in the same cycle
    step(1, 'h0AB, 3, 3, 1, 3, 7, 'h0AB, mk4(2, 0, 0, 0));
    rd('h0AB, 3, 3);
    rd('h0AB, 3, 1);           // R2: result then held
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      int f, m, t;
      f = $urandom_range(0, 2);
      if (f == 0) m = mk4($urandom_range(0, 7), $urandom_range(0, 7),
                          $urandom_range(0, 7), $urandom_range(0, 7));
      else if (f == 1) m = mk2($urandom_range(0, 3), $urandom_range(0, 7),
                               $urandom_range(0, 3), $urandom_range(0, 7));
      else m = mk1($urandom_range(0, 3), $urandom_range(0, 7));
      t = $urandom_range(0, 1) ? 'h3C1 : 'h3C2;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) ? 'h3C1 : 'h3C2,
           $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 1) == 1, $urandom_range(0, 3),
           $urandom_range(0, NW - 1), t, m);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    checkAll();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(20 * 100000);
    misses++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule